// File: doc/BRIEF.md
# Capture/Compare Timer Channel Bank

This block is a bank of eight timer channels that share one free-running 16-bit counter. A select bit gives each channel one of two roles. As an input capture, the channel records the counter value when its pin rises. As an output compare, the channel changes its pin level when the counter reaches its 16-bit compare value. Software can also trigger a compare channel's pin action directly through a force register. A force acts on the pin but never raises the channel's event flag.

The block also decides who drives each pin. An output-compare channel with a pin action takes over its pin and drives it whatever the data-direction bit says. Any other pin is plain general-purpose I/O: its data-direction bit enables the driver, and the level comes from the port latch. Port writes always land in that latch, even while the timer owns the pin. So when the timer lets go of a pin, the last written port value appears on it.

Software reaches all of this through a single-cycle register bus. Writes are strobed on the clock, and reads are combinational from the address.

Top module: `cc_timer_bank`

## Requirements
- R1: After reset, the mode, action, flag, port and direction registers read 0x0000, and no pin is driven (pinOe = 0).
- R2: The mode register at address 0x80 can be read and written at any time. Bit n = 1 makes channel n an output compare, and bit n = 0 makes it an input capture. The register changes only when it is written.
- R3: A read at address 0x81 (the force register) always returns 0x0000, including just after a write with bits set.
- R4: Writing 1 to bit n at address 0x81 applies output-compare channel n's pin action at that clock edge. It leaves every event flag unchanged. A force on an input-capture channel has no effect.
- R5: When an output-compare channel's compare register (address 0x88+n) equals the counter, the channel's flag and pin action take effect at that clock edge. They are visible in the following cycle.
- R6: The pin action of channel n sits in bits [2n+1:2n] of address 0x82, with these codes: 00 leaves the pin level alone, 01 toggles it, 10 drives it low, 11 drives it high.
- R7: Flags read at address 0x83 and appear on chFlag. Writing 1 to flag bit n clears it, and writing 0 leaves it alone. If a set and a clear happen in the same cycle, the set wins.
- R8: An input-capture channel loads the counter value into its register at a rising edge of its pinIn bit and sets its flag. A falling edge does nothing, and an output-compare channel never captures.
- R9: An output-compare channel with a non-00 action owns its pin. The pin is then driven (pinOe = 1) with the channel's level, whatever the direction register (address 0x85) holds.
- R10: A port write (address 0x84) to an owned pin leaves the pin unchanged but stores the value. Once the pin is released, it shows the stored value.
- R11: The counter (read at address 0x87) steps by one every clock and wraps modulo 2^16.
- R12: A pin that is not owned has pinOe equal to its direction bit and pinOut equal to its port latch bit. The pin levels can be read at address 0x86.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWrData | input | 16 | Write data |
| busWrEn | input | 1 | Write strobe, sampled on the rising clock edge |
| busRdData | output | 16 | Combinational read data for busAddr |
| pinIn | input | 8 | Pin levels seen from outside |
| pinOut | output | 8 | Pin levels driven out |
| pinOe | output | 8 | Per-pin output enable |
| chFlag | output | 8 | Per-channel event flags |

## Verification
Some properties are checked by assertions on every cycle:
- the counter steps by one each clock;
- owned pins are always driven;
- unowned pins follow their direction bits;
- the force address always reads zero;
- the mode bits change only on a write.

The bench's scenarios are needed for the rest. These include the exact cycle in which a compare match flips a pin and raises its flag, and a force that changes the pin but leaves the flag clear. They also cover the captured counter value on a rising edge, write-one-to-clear of a flag, and the stored port level that appears once the timer releases a pin.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  parameter int CH_N  = 8;
  parameter int CNT_W = 16;
  parameter int DW    = 16;
  parameter int AW    = 8;
  localparam int CH_IDX_W = $clog2(CH_N);

  localparam logic [AW-1:0] A_SEL   = 8'h80;
  localparam logic [AW-1:0] A_FORCE = 8'h81;
  localparam logic [AW-1:0] A_ACT   = 8'h82;
  localparam logic [AW-1:0] A_FLAG  = 8'h83;
  localparam logic [AW-1:0] A_PORT  = 8'h84;
  localparam logic [AW-1:0] A_DDR   = 8'h85;
  localparam logic [AW-1:0] A_PIN   = 8'h86;
  localparam logic [AW-1:0] A_CNT   = 8'h87;
  localparam logic [AW-1:0] A_CMP   = 8'h88;

  localparam logic [1:0] ACT_NONE = 2'b00;
  localparam logic [1:0] ACT_TOG  = 2'b01;
  localparam logic [1:0] ACT_LOW  = 2'b10;
  localparam logic [1:0] ACT_HIGH = 2'b11;

  typedef enum logic [3:0] {
    RD_ZERO, RD_SEL, RD_ACT, RD_FLAG, RD_PORT, RD_DDR, RD_PIN, RD_CNT, RD_CMP
  } rd_sel_e;

  typedef struct packed {
    logic                wrSel;
    logic                wrForce;
    logic                wrAct;
    logic                wrFlag;
    logic                wrPort;
    logic                wrDdr;
    logic                wrCmp;
    logic [CH_IDX_W-1:0] chIdx;
    rd_sel_e             rdSel;
  } strb_t;
endpackage

// File: rtl/cc_timer_ctrl.sv
module cc_timer_ctrl
  import cc_timer_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strb_t             stb
);
  localparam logic [ADDR_W-1:0] CMP_LO = ADDR_W'(A_CMP);
  localparam logic [ADDR_W-1:0] CMP_HI = ADDR_W'(A_CMP) + ADDR_W'(NUM_CH - 1);

  logic inCmp;
  assign inCmp = (busAddr >= CMP_LO) && (busAddr <= CMP_HI);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_ZERO;
    stb.chIdx = CH_IDX_W'(busAddr - CMP_LO);
    case (busAddr)
      ADDR_W'(A_SEL):   begin stb.rdSel = RD_SEL;  stb.wrSel   = busWrEn; end
      ADDR_W'(A_FORCE): begin stb.rdSel = RD_ZERO; stb.wrForce = busWrEn; end
      ADDR_W'(A_ACT):   begin stb.rdSel = RD_ACT;  stb.wrAct   = busWrEn; end
      ADDR_W'(A_FLAG):  begin stb.rdSel = RD_FLAG; stb.wrFlag  = busWrEn; end
      ADDR_W'(A_PORT):  begin stb.rdSel = RD_PORT; stb.wrPort  = busWrEn; end
      ADDR_W'(A_DDR):   begin stb.rdSel = RD_DDR;  stb.wrDdr   = busWrEn; end
      ADDR_W'(A_PIN):   stb.rdSel = RD_PIN;
      ADDR_W'(A_CNT):   stb.rdSel = RD_CNT;
      default: begin
        if (inCmp) begin
          stb.rdSel = RD_CMP;
          stb.wrCmp = busWrEn;
        end
      end
    endcase
  end
endmodule

// File: rtl/cc_timer_dp.sv
module cc_timer_dp
  import cc_timer_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int CW     = CNT_W,
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] pinOe,
  output logic [NUM_CH-1:0] flagVec,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     cntVal,
  output logic [NUM_CH-1:0] selBits,
  output logic [2*NUM_CH-1:0] actBits,
  output logic [NUM_CH-1:0] ddrBits
);
  logic [CW-1:0]        cnt;
  logic [NUM_CH-1:0]    selReg, ddrReg, portReg, pinPrev, ownVec;
  logic [2*NUM_CH-1:0]  actReg;
  logic [NUM_CH*CW-1:0] cmpFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      selReg  <= '0;
      ddrReg  <= '0;
      portReg <= '0;
      actReg  <= '0;
      pinPrev <= '0;
    end else begin
      cnt     <= cnt + 1'b1;
      pinPrev <= pinIn;
      if (stb.wrSel)  selReg  <= wrData[NUM_CH-1:0];
      if (stb.wrDdr)  ddrReg  <= wrData[NUM_CH-1:0];
      if (stb.wrPort) portReg <= wrData[NUM_CH-1:0];
      if (stb.wrAct)  actReg  <= wrData[2*NUM_CH-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CW-1:0] cmpR;
    logic          lvlR, flagR, hit, frc, rise;
    logic [1:0]    chAct;

    assign chAct = actReg[2*i +: 2];
    assign hit   = selReg[i] && (cnt == cmpR);
    assign frc   = stb.wrForce && wrData[i] && selReg[i];
    assign rise  = !selReg[i] && pinIn[i] && !pinPrev[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpR  <= '0;
        lvlR  <= 1'b0;
        flagR <= 1'b0;
      end else begin
        if (rise)
          cmpR <= cnt;
        else if (stb.wrCmp && (stb.chIdx == CH_IDX_W'(i)))
          cmpR <= CW'(wrData);
        if (hit || frc) begin
          case (chAct)
            ACT_TOG:  lvlR <= ~lvlR;
            ACT_LOW:  lvlR <= 1'b0;
            ACT_HIGH: lvlR <= 1'b1;
            default:  lvlR <= lvlR;
          endcase
        end
        if (hit || rise)
          flagR <= 1'b1;
        else if (stb.wrFlag && wrData[i])
          flagR <= 1'b0;
      end
    end

    assign ownVec[i]            = selReg[i] && (chAct != ACT_NONE);
    assign pinOe[i]             = ownVec[i] | ddrReg[i];
    assign pinOut[i]            = ownVec[i] ? lvlR : portReg[i];
    assign flagVec[i]           = flagR;
    assign cmpFlat[i*CW +: CW]  = cmpR;
  end

  always_comb begin
    case (stb.rdSel)
      RD_SEL:  rdData = DATA_W'(selReg);
      RD_ACT:  rdData = DATA_W'(actReg);
      RD_FLAG: rdData = DATA_W'(flagVec);
      RD_PORT: rdData = DATA_W'(portReg);
      RD_DDR:  rdData = DATA_W'(ddrReg);
      RD_PIN:  rdData = DATA_W'(pinIn);
      RD_CNT:  rdData = DATA_W'(cnt);
      RD_CMP:  rdData = DATA_W'(cmpFlat[stb.chIdx*CW +: CW]);
      default: rdData = '0;
    endcase
  end

  assign cntVal  = cnt;
  assign selBits = selReg;
  assign actBits = actReg;
  assign ddrBits = ddrReg;
endmodule

// File: rtl/cc_timer_bank.sv
module cc_timer_bank
  import cc_timer_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int CW     = CNT_W,
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [NUM_CH-1:0] pinIn,
  output logic [NUM_CH-1:0] pinOut,
  output logic [NUM_CH-1:0] pinOe,
  output logic [NUM_CH-1:0] chFlag
);
  strb_t                stb;
  logic [CW-1:0]        cntVal;
  logic [NUM_CH-1:0]    selBits, ddrBits;
  logic [2*NUM_CH-1:0]  actBits;

  cc_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .stb(stb)
  );

  cc_timer_dp #(.NUM_CH(NUM_CH), .CW(CW), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .flagVec(chFlag), .rdData(busRdData),
    .cntVal(cntVal), .selBits(selBits), .actBits(actBits), .ddrBits(ddrBits)
  );
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
#(
  parameter int NUM_CH = CH_N,
  parameter int CW     = CNT_W,
  parameter int DATA_W = DW,
  parameter int ADDR_W = AW
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWrEn,
  input logic [DATA_W-1:0]   busRdData,
  input logic [NUM_CH-1:0]   pinOe,
  input logic [CW-1:0]       cntVal,
  input logic [NUM_CH-1:0]   selBits,
  input logic [2*NUM_CH-1:0] actBits,
  input logic [NUM_CH-1:0]   ddrBits
);
  logic armed;
  logic [NUM_CH-1:0] ownMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  always_comb begin
    for (int k = 0; k < NUM_CH; k++)
      ownMask[k] = selBits[k] && (actBits[2*k +: 2] != 2'b00);
  end

  p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> cntVal == CW'($past(cntVal) + 1'b1));

  p_owned_driven_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ownMask & ~pinOe) == '0);

  p_gpio_dir_r12: assert property (@(posedge clk) disable iff (!rstN)
    (~ownMask & (pinOe ^ ddrBits)) == '0);

  p_force_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(A_FORCE)) |-> (busRdData == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !(busWrEn && busAddr == ADDR_W'(A_SEL))) |=> $stable(selBits));
endmodule

bind cc_timer_bank cc_timer_chk #(
  .NUM_CH(NUM_CH), .CW(CW), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdData(busRdData), .pinOe(pinOe), .cntVal(cntVal), .selBits(selBits),
  .actBits(actBits), .ddrBits(ddrBits)
);

// File: tb/sim_cc_timer_bank.sv
module sim_cc_timer_bank;
  import cc_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [15:0] busWrData = 16'h0;
  logic        busWrEn = 1'b0;
  logic [15:0] busRdData;
  logic [7:0]  pinIn = 8'h00;
  logic [7:0]  pinOut, pinOe, chFlag;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cc_timer_bank u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .chFlag(chFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  function automatic logic [7:0] ownOf(input logic [7:0] s, input logic [15:0] a);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) o[k] = s[k] && (a[2*k +: 2] != 2'b00);
    return o;
  endfunction

  function automatic logic [7:0] expOe(input logic [7:0] s, input logic [15:0] a, input logic [7:0] d);
    return ownOf(s, a) | d;
  endfunction

  function automatic logic [7:0] expOut(input logic [7:0] s, input logic [15:0] a,
                                        input logic [7:0] p, input logic [7:0] l);
    logic [7:0] o;
    o = ownOf(s, a);
    return (o & l) | (~o & p);
  endfunction

  function automatic logic [7:0] applyForce(input logic [7:0] s, input logic [15:0] a,
                                            input logic [7:0] f, input logic [7:0] l);
    logic [7:0] n;
    n = l;
    for (int k = 0; k < 8; k++) begin
      if (s[k] && f[k]) begin
        case (a[2*k +: 2])
          2'b01: n[k] = ~l[k];
          2'b10: n[k] = 1'b0;
          2'b11: n[k] = 1'b1;
          default: n[k] = l[k];
        endcase
      end
    end
    return n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c;
    logic [7:0]  mSel, mDdr, mPort, mLvl, f;
    logic [15:0] mAct;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_SEL, v);  chk("R1 mode", v, 0);
    rd(A_ACT, v);  chk("R1 action", v, 0);
    rd(A_FLAG, v); chk("R1 flags", v, 0);
    rd(A_PORT, v); chk("R1 port", v, 0);
    rd(A_DDR, v);  chk("R1 dir", v, 0);
    chk("R1 pinOe", pinOe, 0);

    // R2 mode register
    wr(A_SEL, 16'h00A5);
    rd(A_SEL, v); chk("R2 mode readback", v, 16'h00A5);

    // R3 force reads zero
    wr(A_FORCE, 16'h00FF);
    rd(A_FORCE, v); chk("R3 force read", v, 0);

    // R11 counter step
    rd(A_CNT, c);
    repeat (5) @(negedge clk);
    rd(A_CNT, v); chk("R11 counter step", v, c + 16'd5);

    // R4 / R6 force with codes: ch0 toggle, ch1 low, ch2 high, ch3 none
    wr(A_SEL, 16'h000F);
    wr(A_ACT, 16'h0039);
    chk("R9 owned pins oe", pinOe, 8'h07);
    chk("R6 levels before force", pinOut[2:0], 3'b000);
    wr(A_FORCE, 16'h000F);
    chk("R6 levels after force", pinOut[2:0], 3'b101);
    chk("R4 ch3 none not driven", pinOe[3], 1'b0);
    chk("R4 force leaves flags", chFlag, 0);
    wr(A_FORCE, 16'h0001);
    chk("R6 toggle back", pinOut[0], 1'b0);

    // R5 compare match timing on ch0 (toggle)
    rd(A_CNT, c);
    wr(A_CMP, c + 16'd16);
    for (int k = 0; k < 40; k++) begin
      rd(A_CNT, v);
      if (v == c + 16'd16) break;
      @(negedge clk);
    end
    chk("R5 flag before edge", chFlag[0], 1'b0);
    chk("R5 pin before edge", pinOut[0], 1'b0);
    @(negedge clk);
    chk("R5 flag after match", chFlag[0], 1'b1);
    chk("R5 pin after match", pinOut[0], 1'b1);

    // R7 flag clearing
    wr(A_FLAG, 16'h0000);
    chk("R7 write zero keeps", chFlag[0], 1'b1);
    wr(A_FLAG, 16'h0001);
    chk("R7 write one clears", chFlag[0], 1'b0);

    // R10 / R12 port latch and ownership
    wr(A_DDR, 16'h00FF);
    wr(A_PORT, 16'h0000);
    chk("R10 owned pin unchanged", pinOut[2], 1'b1);
    rd(A_PORT, v); chk("R10 latch stored", v, 0);
    wr(A_ACT, 16'h0009);
    chk("R10 released shows latch", pinOut[2], 1'b0);
    chk("R12 released oe from dir", pinOe[2], 1'b1);
    wr(A_PORT, 16'h0004);
    chk("R12 gpio out", pinOut[2], 1'b1);
    wr(A_DDR, 16'h0000);
    chk("R12 gpio oe off", pinOe[7:2], 6'b0);
    chk("R9 owned ignores dir", pinOe[1:0], 2'b11);
    pinIn = 8'h24;
    #1;
    rd(A_PIN, v); chk("R12 pin read", v, 16'h0024);
    pinIn = 8'h00;
    @(negedge clk);

    // R8 capture on ch5
    rd(A_CNT, c);
    pinIn[5] = 1'b1;
    @(negedge clk);
    chk("R8 capture flag", chFlag[5], 1'b1);
    rd(A_CMP + 8'd5, v); chk("R8 captured value", v, c);
    wr(A_FLAG, 16'h0020);
    pinIn[5] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 falling no flag", chFlag[5], 1'b0);
    rd(A_CMP + 8'd5, v); chk("R8 falling keeps value", v, c);
    pinIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 compare channel no capture", chFlag[0], 1'b0);
    pinIn = 8'h00;

    // Random phase: compares parked far away, levels brought to zero
    for (int k = 0; k < 8; k++) wr(A_CMP + 8'(k), 16'hFFFF);
    wr(A_FLAG, 16'h00FF);
    wr(A_SEL, 16'h00FF);
    wr(A_ACT, 16'hFFFF);
    wr(A_FORCE, 16'h00FF);
    wr(A_ACT, 16'hAAAA);
    wr(A_FORCE, 16'h00FF);
    mSel = 8'hFF; mAct = 16'hAAAA; mDdr = 8'h00; mPort = 8'h04; mLvl = 8'h00;
    chk("R6 random start levels", pinOut, 8'h00);

    for (int it = 0; it < 300; it++) begin
      case ($urandom_range(0, 4))
        0: begin mSel = 8'($urandom); wr(A_SEL, {8'h0, mSel}); end
        1: begin mAct = 16'($urandom); wr(A_ACT, mAct); end
        2: begin mDdr = 8'($urandom); wr(A_DDR, {8'h0, mDdr}); end
        3: begin mPort = 8'($urandom); wr(A_PORT, {8'h0, mPort}); end
        default: begin
          f = 8'($urandom);
          mLvl = applyForce(mSel, mAct, f, mLvl);
          wr(A_FORCE, {8'h0, f});
        end
      endcase
      chk("R9 R12 random oe", pinOe, expOe(mSel, mAct, mDdr));
      chk("R4 R10 random out", pinOut, expOut(mSel, mAct, mPort, mLvl));
      chk("R4 random flags", chFlag, 0);
    end
    rd(A_PORT, v); chk("R10 latch final", v, {8'h0, mPort});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule